// File: doc/BRIEF.md
# Dual-Rail Word Link

This block moves a word between two parties over a dual-rail channel with a four-phase acknowledge. Each data bit travels on a pair of wires: one rail for "one" and one rail for "zero". Both rails low means the pair carries no data, and that state is called the spacer. The receiving side does not use a strobe to decide when a word has arrived. It checks every pair, and it decides the word is complete once each pair holds exactly one raised rail.

The sending half takes a single-rail word and a valid strobe. It drives the codeword and holds it until the acknowledge comes back high. It then returns every pair to spacer and waits for the acknowledge to fall before it accepts another word. The receiving half merges per-bit validity flags through a tree of agreement gates into one C-element style state bit, and that bit is the acknowledge. When the acknowledge rises, the receiver presents the decoded word with a one-cycle pulse. A pair with both rails high is reported as a protocol error and is never acknowledged.

Everything is sampled on one system clock. The two halves have separate ports, so they can be looped back or driven independently.

Top module: `dr_link`

## Requirements
- R1: After reset, `tx_true` and `tx_false` are all zero (spacer), `rx_ack`, `rx_strobe` and `rx_err` are 0, and `tx_ready` is 1 while `tx_ack` is 0.
- R2: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle, bit i of `tx_true` equals word bit i and bit i of `tx_false` equals its inverse (logic 1 = true rail high only, logic 0 = false rail high only).
- R3: `tx_ready` is 1 exactly when the sender is not holding a codeword and `tx_ack` is 0. No word is accepted at any other time, whatever `tx_word` and `tx_valid` do.
- R4: The sender holds its codeword unchanged while `tx_ack` is 0. On the first edge where `tx_ack` is 1, it returns all pairs to spacer.
- R5: `rx_ack` rises on the edge after a cycle in which every received pair holds exactly one raised rail.
- R6: `rx_ack` falls on the edge after a cycle in which every received pair is spacer.
- R7: On the edge where `rx_ack` rises, `rx_strobe` is 1 for exactly one cycle and `rx_word` takes the true rails. `rx_word` holds that value until the next rise.
- R8: If any received pair has both rails high, `rx_err` is 1 in the next cycle. While that lasts, `rx_ack` does not rise.
- R9: While the received pairs are a mix of valid pairs and spacer pairs, `rx_ack` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | WIDTH | Single-rail word to send |
| tx_valid | input | 1 | Word offered to the sender |
| tx_ready | output | 1 | Sender will take the word on this edge |
| tx_true | output | WIDTH | Sender one-rails |
| tx_false | output | WIDTH | Sender zero-rails |
| tx_ack | input | 1 | Acknowledge returned to the sender |
| rx_true | input | WIDTH | Receiver one-rails |
| rx_false | input | WIDTH | Receiver zero-rails |
| rx_ack | output | 1 | Acknowledge from the receiver |
| rx_word | output | WIDTH | Last decoded word |
| rx_strobe | output | 1 | One-cycle pulse when a word is decoded |
| rx_err | output | 1 | Some pair has both rails high |

## Verification
The bench builds the link with WIDTH = 5. That width is not a power of two, so the completion tree has padded leaves that must stay neutral for both the all-valid and all-spacer decisions. It is small enough that the all-zero and all-one words, single-pair partial arrivals and a both-high fault on an edge pair can all be driven directly. Most traffic is looped back from sender to receiver, with back-to-back words and with gaps. An override path then injects partial, mixed and illegal rail patterns into the receiver alone.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SENT = 1'b1
  } tx_state_e;
endpackage

// File: rtl/dr_agree_tree.sv
// Reduces per-bit flags into "all high" and "all low" through a balanced
// tree of two-input agreement nodes; padded leaves are neutral.
module dr_agree_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0] flag,
  output logic         all_hi,
  output logic         all_lo
);
  localparam int LVL = (N <= 1) ? 1 : $clog2(N);
  localparam int NP  = 1 << LVL;

  logic [2*NP-1:1] hi;
  logic [2*NP-1:1] lo;

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign hi[NP+i] = flag[i];
      assign lo[NP+i] = ~flag[i];
    end else begin : g_pad
      assign hi[NP+i] = 1'b1;
      assign lo[NP+i] = 1'b1;
    end
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    assign hi[k] = hi[2*k] & hi[2*k+1];
    assign lo[k] = lo[2*k] & lo[2*k+1];
  end

  assign all_hi = hi[1];
  assign all_lo = lo[1];
endmodule

// File: rtl/dr_c_gate.sv
// Root state element: set when all inputs agree high, clear when all agree
// low, otherwise hold.
module dr_c_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;
  logic q_r;

  always_comb begin
    q_d = q_r;
    if (set)      q_d = 1'b1;
    else if (clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/dr_tx.sv
module dr_tx
  import dr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] word,
  input  logic             valid,
  output logic             ready,
  input  logic             ack,
  output logic [WIDTH-1:0] rail_t,
  output logic [WIDTH-1:0] rail_f
);
  tx_state_e        state_q, state_d;
  logic [WIDTH-1:0] t_q, t_d, f_q, f_d;
  logic             take, drop, en;

  assign ready = (state_q == TX_IDLE) && !ack;
  assign take  = ready && valid;
  assign drop  = (state_q == TX_SENT) && ack;
  assign en    = take || drop;

  always_comb begin
    state_d = state_q;
    t_d     = t_q;
    f_d     = f_q;
    if (take) begin
      state_d = TX_SENT;
      t_d     = word;
      f_d     = ~word;
    end else if (drop) begin
      state_d = TX_IDLE;
      t_d     = '0;
      f_d     = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      t_q     <= '0;
      f_q     <= '0;
    end else if (en) begin
      state_q <= state_d;
      t_q     <= t_d;
      f_q     <= f_d;
    end
  end

  assign rail_t = t_q;
  assign rail_f = f_q;

  // R4: codeword held while waiting for the acknowledge
  assert_hold_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SENT && !ack) |=> ($stable(rail_t) && $stable(rail_f)));

  // R4: return to spacer once acknowledged
  assert_rtz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_SENT && ack) |=> (rail_t == '0 && rail_f == '0));

  // R2: accepted word appears as complementary rails
  assert_encode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready) |=> (rail_t == $past(word) && rail_f == ~$past(word)));
endmodule

// File: rtl/dr_rx.sv
module dr_rx #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic             ack,
  output logic [WIDTH-1:0] word,
  output logic             strobe,
  output logic             err
);
  logic [WIDTH-1:0] bit_ok;
  logic [WIDTH-1:0] bit_bad;
  logic             all_ok, none_ok, any_bad, all_spacer, rise;
  logic [WIDTH-1:0] word_q, word_d;
  logic             stb_q, stb_d, err_q, err_d;

  assign bit_ok  = rail_t ^ rail_f;
  assign bit_bad = rail_t & rail_f;
  assign any_bad = |bit_bad;

  dr_agree_tree #(.N(WIDTH)) u_tree (
    .flag   (bit_ok),
    .all_hi (all_ok),
    .all_lo (none_ok)
  );

  assign all_spacer = none_ok && !any_bad;

  dr_c_gate u_root (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (all_ok),
    .clr   (all_spacer),
    .q     (ack)
  );

  assign rise = all_ok && !ack;

  always_comb begin
    word_d = rise ? rail_t : word_q;
    stb_d  = rise;
    err_d  = any_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rise) word_q <= word_d;
      stb_q <= stb_d;
      err_q <= err_d;
    end
  end

  assign word   = word_q;
  assign strobe = stb_q;
  assign err    = err_q;

  // R5: complete codeword raises the acknowledge
  assert_ack_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (all_ok && !ack) |=> ack);

  // R6: full spacer drops the acknowledge
  assert_ack_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (all_spacer && ack) |=> !ack);

  // R8: illegal pair blocks the acknowledge and raises the error
  assert_bad_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_bad && !ack) |=> (!ack && err));

  // R7: strobe only on the acknowledge rise
  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (ack && !$past(ack)));

  // R9: mixed pairs leave the acknowledge alone
  assert_mixed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_ok && !all_spacer) |=> (ack == $past(ack)));
endmodule

// File: rtl/dr_link.sv
module dr_link #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] tx_word,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [WIDTH-1:0] tx_true,
  output logic [WIDTH-1:0] tx_false,
  input  logic             tx_ack,
  input  logic [WIDTH-1:0] rx_true,
  input  logic [WIDTH-1:0] rx_false,
  output logic             rx_ack,
  output logic [WIDTH-1:0] rx_word,
  output logic             rx_strobe,
  output logic             rx_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  dr_tx #(.WIDTH(WIDTH)) u_tx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .word   (tx_word),
    .valid  (tx_valid),
    .ready  (tx_ready),
    .ack    (tx_ack),
    .rail_t (tx_true),
    .rail_f (tx_false)
  );

  dr_rx #(.WIDTH(WIDTH)) u_rx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rail_t (rx_true),
    .rail_f (rx_false),
    .ack    (rx_ack),
    .word   (rx_word),
    .strobe (rx_strobe),
    .err    (rx_err)
  );
endmodule

// File: tb/sim_dr_link.sv
module sim_dr_link;
  localparam int BW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] tx_word = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic [BW-1:0] tx_true, tx_false;
  logic [BW-1:0] rx_true, rx_false;
  logic          rx_ack, rx_strobe, rx_err;
  logic [BW-1:0] rx_word;
  logic          inj = 1'b0;
  logic [BW-1:0] inj_t = '0, inj_f = '0;
  logic          run = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign rx_true  = inj ? inj_t : tx_true;
  assign rx_false = inj ? inj_f : tx_false;

  dr_link #(.WIDTH(BW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_true(tx_true), .tx_false(tx_false), .tx_ack(rx_ack),
    .rx_true(rx_true), .rx_false(rx_false),
    .rx_ack(rx_ack), .rx_word(rx_word), .rx_strobe(rx_strobe), .rx_err(rx_err)
  );

  // behavioural reference model
  bit          m_sent = 0;
  bit [BW-1:0] m_t = 0, m_f = 0;
  bit          m_ack = 0, m_stb = 0, m_err = 0;
  bit [BW-1:0] m_word = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sent <= 0; m_t <= 0; m_f <= 0;
      m_ack <= 0; m_stb <= 0; m_err <= 0; m_word <= 0;
    end else begin
      bit [BW-1:0] rt, rf;
      int nvalid, nspace, nbad;
      if (!m_sent && !m_ack && tx_valid) begin
        m_sent <= 1; m_t <= tx_word; m_f <= ~tx_word;
      end else if (m_sent && m_ack) begin
        m_sent <= 0; m_t <= 0; m_f <= 0;
      end
      rt = inj ? inj_t : m_t;
      rf = inj ? inj_f : m_f;
      nvalid = 0; nspace = 0; nbad = 0;
      for (int i = 0; i < BW; i++) begin
        if (rt[i] && rf[i]) nbad++;
        else if (rt[i] || rf[i]) nvalid++;
        else nspace++;
      end
      m_err <= (nbad > 0);
      m_stb <= 0;
      if (nvalid == BW && !m_ack) begin
        m_ack <= 1; m_stb <= 1; m_word <= rt;
      end else if (nspace == BW) begin
        m_ack <= 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk(tx_true == m_t && tx_false == m_f, "R2 R4 rails",
          {tx_true, tx_false}, {m_t, m_f});
      chk(tx_ready == (!m_sent && !m_ack), "R3 ready", tx_ready, !m_sent && !m_ack);
      chk(rx_ack == m_ack, "R5 R6 R9 ack", rx_ack, m_ack);
      chk(rx_strobe == m_stb, "R7 strobe", rx_strobe, m_stb);
      chk(rx_word == m_word, "R7 word", rx_word, m_word);
      chk(rx_err == m_err, "R8 err", rx_err, m_err);
    end
  end

  task automatic send(input logic [BW-1:0] w);
    forever begin
      @(negedge clk);
      tx_valid = 1'b1;
      if (tx_ready) begin
        tx_word = w;
        break;
      end
      tx_word = ~w ^ BW'(5'h13);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drive(input logic [BW-1:0] t, input logic [BW-1:0] f, input int n);
    @(negedge clk);
    inj = 1'b1; inj_t = t; inj_f = f;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [BW-1:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tx_true == '0 && tx_false == '0, "R1 rails spacer", {tx_true, tx_false}, 0);
    chk(!rx_ack && !rx_strobe && !rx_err, "R1 rx idle", {rx_ack, rx_strobe, rx_err}, 0);
    chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    run = 1'b1;

    // loopback, back-to-back and with gaps
    send('0); send('1); send(5'h15); send(5'h0A);
    idle(3);
    lf = 5'h1;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[BW-2:0], lf[BW-1] ^ lf[2]};
      send(lf);
      if (n % 3 == 0) idle(n % 5 + 1);
    end
    idle(6);

    // receiver-only patterns
    drive(5'h01, 5'h00, 3);            // R9 partial arrival, no ack
    chk(rx_ack == 1'b0, "R9 partial no rise", rx_ack, 0);
    drive(5'h01, 5'h1C, 2);            // still one spacer pair
    drive(5'h03, 5'h1C, 2);            // complete: word 0x03
    chk(rx_ack == 1'b1 && rx_word == 5'h03, "R5 R7 rise word", rx_word, 5'h03);
    drive(5'h03, 5'h00, 3);            // R9 partial return, ack held
    chk(rx_ack == 1'b1, "R9 partial hold high", rx_ack, 1);
    drive(5'h00, 5'h00, 2);            // R6 spacer drops ack
    chk(rx_ack == 1'b0, "R6 fall", rx_ack, 0);
    drive(5'h10, 5'h1F, 3);            // R8 both-high on top pair
    chk(rx_err == 1'b1 && rx_ack == 1'b0, "R8 err no ack", {rx_err, rx_ack}, 2'b10);
    drive(5'h1F, 5'h1F, 2);
    chk(rx_ack == 1'b0, "R8 all bad no ack", rx_ack, 0);
    drive(5'h00, 5'h00, 2);
    chk(rx_err == 1'b0, "R8 err clears", rx_err, 0);
    drive(5'h1F, 5'h00, 2);
    chk(rx_word == 5'h1F, "R7 word all ones", rx_word, 5'h1F);
    drive(5'h00, 5'h00, 2);
    @(negedge clk);
    inj = 1'b0;

    // more loopback after injection
    send(5'h11); send(5'h0E);
    idle(8);
    run = 1'b0;
    finish_run();
  end
endmodule